// File: doc/BRIEF.md
# Register-Window I2C Master

This block is an I2C bus master that a host drives through a small window of 16-bit registers. Before a write, the host places one or two data bytes in a transmit staging register. It then writes a single command word that carries the 7-bit target address, the transfer direction, the byte count and a flag that keeps the bus held. That one command write starts a whole bus transaction: START (or repeated START), address byte, data bytes, and then either STOP or a held bus.

When the transaction ends, the block sets one of three sticky event bits: write finished, read finished, or error. Each bit is cleared by writing a one to it. An interrupt line is raised whenever a set event bit is also enabled. Bytes read from the target are placed in a receive staging register.

Longer transfers are built from a chain of commands with the hold flag set on all but the last. An address-only command with the read direction probes whether a target is present.

The bus pins are open-drain. The block only ever pulls SCL and SDA low; to release a line it stops driving it and lets the line float high. The bit rate is set by a quarter-bit prescaler parameter.

Top module: `i2c_mailbox_master`

## Requirements
- R1: After reset, every event bit and every enable bit is 0, both staging registers are 0, the interrupt is 0 and neither SCL nor SDA is pulled low.
- R2: Register offsets are fixed. Offset 0x0 is event status. Offset 0x2 is the interrupt enable, using bits 15:13. Offset 0x4 is the transmit staging register. Offset 0x6 is the command register. Offset 0x8 is the receive staging register. Offset 0xA is a read-only word whose bit 0 is 1 while a transaction is running. The enable and transmit staging registers read back what was written.
- R3: The command word is laid out as follows. Bits 15:14 must be 2'b10; any other value makes the whole command write ignored. Bit 13 is the hold flag. Bit 12 means address only, with no data phase. Bit 11 selects two data bytes (0 selects one). Bit 10 is the direction (1 = write, 0 = read). Bits 7:1 are the target address. For a write, the byte in bits 7:0 of the transmit staging register goes on the bus first, followed by bits 15:8 when two bytes are selected.
- R4: A write that completes sets event bit 14 alone and ends with a STOP, after which both lines are released.
- R5: A read that completes sets event bit 15 and places the first received byte in bits 7:0 and the second in bits 15:8 of the receive staging register. The master acknowledges every received byte except the last, which it does not acknowledge.
- R6: An address-only command completes. It sets event bit 13 when the target does not acknowledge. When the target does acknowledge, it sets the direction's normal event (bit 15 for a read).
- R7: A missing acknowledge on the address byte or on any written byte ends the transaction with a STOP, sets event bit 13 and sets neither bit 14 nor bit 15.
- R8: With the hold flag set, the block ends the command without a STOP and keeps SCL pulled low. The next command then begins with a repeated START.
- R9: Writing a 1 to a status bit clears that bit. Writing a 0 leaves the bit unchanged.
- R10: The interrupt output is high exactly when some event bit and its matching enable bit are both set.
- R11: A command write that arrives while a transaction is running is ignored. It does not alter the running transaction and does not start another one afterwards.
- R12: One SCL period lasts 4*QDIV clock cycles. SDA changes while SCL is released only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Byte offset within the register window |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data at reg_addr (combinational) |
| irq | output | 1 | Interrupt, the OR of the enabled event bits |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The hardest situation to bring about is the held bus followed by a repeated START. It needs a target model that stays in its data phase across the held gap and then detects a new START with SCL already low. The bench models an open-drain target that watches the resolved lines and follows START and STOP edges. The held write and the read that follows are issued back to back, and SCL is checked to still be pulled low in between. A command written one cycle after another, and a target that refuses written data partway through a two-byte write, cover the collision and early-abort cases.

// File: rtl/i2cmb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the register-window I2C master: register offsets,
// event bit positions, decoded command fields and engine states.
package i2cmb_pkg;
    localparam logic [3:0] OFS_STAT = 4'h0;
    localparam logic [3:0] OFS_IEN  = 4'h2;
    localparam logic [3:0] OFS_WEXT = 4'h4;
    localparam logic [3:0] OFS_CMD  = 4'h6;
    localparam logic [3:0] OFS_REXT = 4'h8;
    localparam logic [3:0] OFS_BUSY = 4'hA;

    typedef struct packed {
        logic [6:0] addr;
        logic       rd;
        logic       two;
        logic       nodata;
        logic       hold;
    } cmd_t;

    typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BYTE, ST_STOP} st_e;

    // Native-mode check on the command word
    function automatic logic cmd_valid(input logic [15:0] w);
        return w[15:14] == 2'b10;
    endfunction

    // Split a command word into its fields
    function automatic cmd_t cmd_decode(input logic [15:0] w);
        cmd_t c;
        c.addr   = w[7:1];
        c.rd     = ~w[10];
        c.two    = w[11];
        c.nodata = w[12];
        c.hold   = w[13];
        return c;
    endfunction
endpackage

// File: rtl/i2cmb_tick.sv
`timescale 1ns/1ps
// Quarter-bit prescaler. Assumes QDIV >= 1. The count restarts whenever en is
// low, so the first tick comes QDIV cycles after a transaction begins.
module i2cmb_tick #(
    parameter int QDIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int W = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [W-1:0] LAST = W'(QDIV - 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == LAST);

    // Count clock cycles within one quarter bit
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cmb_engine.sv
`timescale 1ns/1ps
// Bit-level SCL/SDA sequencer. Each bus bit is split into four quarters:
// set SDA (SCL low), release SCL, sample SDA, pull SCL low. It assumes
// no clock stretching and a single master. go is taken only when idle.
module i2cmb_engine
    import i2cmb_pkg::*;
#(
    parameter int QDIV = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  cmd_t        cmd_i,
    input  logic [15:0] wdat_i,
    input  logic        sda_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic        rd_o,
    output logic [15:0] rdat_o,
    output logic        scl_oe_o,
    output logic        sda_oe_o
);
    st_e        st_q;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [1:0] byten;
    logic [7:0] sh;
    logic       nack_q, held_q;
    cmd_t       cmd_q;
    logic       tick;
    logic [1:0] last_idx;
    logic       txb;

    i2cmb_tick #(.QDIV(QDIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(st_q != ST_IDLE), .tick(tick)
    );

    assign last_idx = cmd_q.nodata ? 2'd0 : (cmd_q.two ? 2'd2 : 2'd1);
    assign txb      = (byten == 2'd0) || !cmd_q.rd;
    assign busy_o   = (st_q != ST_IDLE);
    assign rd_o     = cmd_q.rd;

    // Sequence START, bytes with acknowledge, and STOP or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; q <= '0; bitn <= '0; byten <= '0; sh <= '0;
            nack_q <= 1'b0; held_q <= 1'b0; cmd_q <= '0; done_o <= 1'b0;
            err_o <= 1'b0; rdat_o <= '0; scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (st_q == ST_IDLE) begin
                q <= '0;
                if (go_i) begin
                    cmd_q  <= cmd_i;
                    err_o  <= 1'b0;
                    rdat_o <= '0;
                    st_q   <= ST_START;
                end
            end else if (tick) begin
                q <= q + 1'b1;
                case (st_q)
                    ST_START: begin
                        case (q)
                            2'd0: sda_oe_o <= 1'b0;
                            2'd1: scl_oe_o <= 1'b0;
                            2'd2: sda_oe_o <= 1'b1;
                            default: begin
                                scl_oe_o <= 1'b1;
                                st_q     <= ST_BYTE;
                                bitn     <= '0;
                                byten    <= '0;
                                sh       <= {cmd_q.addr, cmd_q.rd};
                            end
                        endcase
                    end
                    ST_BYTE: begin
                        case (q)
                            2'd0: sda_oe_o <= (bitn < 4'd8) ? (txb & ~sh[7])
                                            : (!txb && byten != last_idx);
                            2'd1: scl_oe_o <= 1'b0;
                            2'd2: begin
                                if (bitn < 4'd8) sh <= {sh[6:0], sda_i};
                                else             nack_q <= sda_i;
                            end
                            default: begin
                                scl_oe_o <= 1'b1;
                                if (bitn < 4'd8) begin
                                    bitn <= bitn + 1'b1;
                                end else begin
                                    if (!txb && byten == 2'd1) rdat_o[7:0]  <= sh;
                                    if (!txb && byten == 2'd2) rdat_o[15:8] <= sh;
                                    if (txb && nack_q) begin
                                        err_o <= 1'b1;
                                        st_q  <= ST_STOP;
                                    end else if (byten == last_idx) begin
                                        if (cmd_q.hold) begin
                                            st_q   <= ST_IDLE;
                                            held_q <= 1'b1;
                                            done_o <= 1'b1;
                                        end else begin
                                            st_q <= ST_STOP;
                                        end
                                    end else begin
                                        byten <= byten + 1'b1;
                                        bitn  <= '0;
                                        sh    <= (byten == 2'd0) ? wdat_i[7:0] : wdat_i[15:8];
                                    end
                                end
                            end
                        endcase
                    end
                    default: begin
                        case (q)
                            2'd0: sda_oe_o <= 1'b1;
                            2'd1: scl_oe_o <= 1'b0;
                            2'd2: sda_oe_o <= 1'b0;
                            default: begin
                                st_q   <= ST_IDLE;
                                held_q <= 1'b0;
                                done_o <= 1'b1;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    // R12
    // sda_only_low_scl_chk
    sda_only_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
        |-> (st_q == ST_START || st_q == ST_STOP));

    // R4
    released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !held_q) |-> (!scl_oe_o && !sda_oe_o));

    // R8
    hold_keeps_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cmd_q.hold && !err_o) |-> scl_oe_o);

    // R11
    cmd_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(cmd_q));
endmodule

// File: rtl/i2c_mailbox_master.sv
`timescale 1ns/1ps
// Register-window I2C master top. It holds the event, enable and staging
// registers and decodes command writes into engine starts. It assumes a
// single-cycle write strobe and combinational reads.
module i2c_mailbox_master
    import i2cmb_pkg::*;
#(
    parameter int QDIV = 125
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    logic [2:0]  ev_q;   // {rx, tx, err} = status bits 15..13
    logic [2:0]  ien_q;
    logic [15:0] wext_q;
    logic [15:0] rext;
    logic        busy, done, err, rd, go;

    assign go = reg_wr && (reg_addr == OFS_CMD) && cmd_valid(reg_wdata) && !busy;

    i2cmb_engine #(.QDIV(QDIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .go_i(go), .cmd_i(cmd_decode(reg_wdata)),
        .wdat_i(wext_q), .sda_i(sda_in), .busy_o(busy), .done_o(done),
        .err_o(err), .rd_o(rd), .rdat_o(rext), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
    );

    // Host-written enable and transmit staging registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wext_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_IEN)  ien_q  <= reg_wdata[15:13];
            if (reg_addr == OFS_WEXT) wext_q <= reg_wdata;
        end
    end

    // Sticky events: write-one-to-clear, a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= (reg_wr && reg_addr == OFS_STAT) ? (ev_q & ~reg_wdata[15:13]) : ev_q;
            if (done) begin
                if (err)     ev_q[0] <= 1'b1;
                else if (rd) ev_q[2] <= 1'b1;
                else         ev_q[1] <= 1'b1;
            end
        end
    end

    assign irq = |(ev_q & ien_q);

    // Register read multiplexer
    always_comb begin
        case (reg_addr)
            OFS_STAT: reg_rdata = {ev_q, 13'b0};
            OFS_IEN:  reg_rdata = {ien_q, 13'b0};
            OFS_WEXT: reg_rdata = wext_q;
            OFS_REXT: reg_rdata = rext;
            OFS_BUSY: reg_rdata = {15'b0, busy};
            default:  reg_rdata = '0;
        endcase
    end

    // R7
    err_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |=> ev_q[0]);

    // R4
    tx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !rd) |=> ev_q[1]);

    // R5
    rx_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && rd) |=> ev_q[2]);
endmodule

// File: tb/sim_i2c_mailbox_master.sv
`timescale 1ns/1ps
module sim_i2c_mailbox_master;
    localparam int QD = 4;
    localparam logic [3:0] A_STAT = 4'h0, A_IEN = 4'h2, A_WEXT = 4'h4,
                           A_CMD = 4'h6, A_REXT = 4'h8, A_BUSY = 4'hA;
    localparam logic [6:0] SL_ADDR = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic sl_drive = 1'b0;
    logic scl_w, sda_w;
    int n_chk = 0, n_fail = 0;
    longint cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | sl_drive);

    i2c_mailbox_master #(.QDIV(QD)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard: bytes the target is expected to receive, in order
    logic [7:0] exp_q[$];
    int ack_log[$];
    logic [7:0] rd_pat[2] = '{8'hA5, 8'h3C};

    // Target model state
    int sl_phase = 0;   // 0 idle, 1 address, 2 write data, 3 read data
    int sl_bit = 0;
    int sl_ridx = 0;
    logic sl_fresh = 1'b0, sl_match = 1'b0, sl_rw = 1'b0, sl_nack_data = 1'b0;
    logic [7:0] sl_sh = '0, sl_rdb = '0;

    always @(negedge sda_w) if (scl_w === 1'b1) begin
        sl_phase = 1; sl_bit = 0; sl_drive = 1'b0; sl_fresh = 1'b1;
    end
    always @(posedge sda_w) if (scl_w === 1'b1) begin
        sl_phase = 0; sl_drive = 1'b0;
    end
    always @(posedge scl_w) if (sl_phase != 0) begin
        if (sl_bit < 8) sl_sh = {sl_sh[6:0], sda_w};
        else if (sl_phase == 3) ack_log.push_back((sda_w === 1'b0) ? 1 : 0);
    end
    // Monitor: end of each bus bit, compare received bytes with the queue
    always @(negedge scl_w) begin
        if (sl_fresh) begin
            sl_fresh = 1'b0;
        end else if (sl_phase != 0) begin
            if (sl_bit < 7) begin
                sl_bit++;
                if (sl_phase == 3) sl_drive = ~sl_rdb[7 - sl_bit];
            end else if (sl_bit == 7) begin
                sl_bit = 8;
                if (sl_phase == 1) begin
                    sl_match = (sl_sh[7:1] == SL_ADDR);
                    sl_rw = sl_sh[0];
                    sl_drive = sl_match;
                end else if (sl_phase == 2) begin
                    if (exp_q.size() == 0) chk("R3 unexpected byte", {24'b0, sl_sh}, 32'hFFFF_FFFF);
                    else chk("R3 write byte order", {24'b0, sl_sh}, {24'b0, exp_q.pop_front()});
                    sl_drive = ~sl_nack_data;
                end else begin
                    sl_drive = 1'b0;
                end
            end else begin
                sl_bit = 0;
                if (sl_phase == 1) begin
                    if (!sl_match) begin sl_phase = 0; sl_drive = 1'b0; end
                    else if (sl_rw) begin
                        sl_phase = 3; sl_ridx = 0; sl_rdb = rd_pat[0]; sl_drive = ~sl_rdb[7];
                    end else begin
                        sl_phase = 2; sl_drive = 1'b0;
                    end
                end else if (sl_phase == 2) begin
                    sl_drive = 1'b0;
                end else begin
                    if (ack_log.size() > 0 && ack_log[ack_log.size()-1] == 1) begin
                        sl_ridx++; sl_rdb = rd_pat[sl_ridx % 2]; sl_drive = ~sl_rdb[7];
                    end else begin
                        sl_phase = 0; sl_drive = 1'b0;
                    end
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_ev(output logic [15:0] s);
        s = '0;
        for (int i = 0; i < 3000 && s[15:13] == 3'b0; i++) rd(A_STAT, s);
    endtask

    function automatic logic [15:0] cmd(input logic [6:0] a, input logic w,
        input logic two, input logic nod, input logic hold);
        return {2'b10, hold, nod, two, w, 2'b00, a, 1'b0};
    endfunction

    // Driver: stage data, record expected bytes, issue a write command
    task automatic drv_write(input logic [6:0] a, input logic two, input logic hold,
                             input logic [15:0] d, input int nexp);
        if (nexp > 0) exp_q.push_back(d[7:0]);
        if (nexp > 1) exp_q.push_back(d[15:8]);
        wr(A_WEXT, d);
        wr(A_CMD, cmd(a, 1'b1, two, 1'b0, hold));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] s, v;
        longint t1, t2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A_STAT, v); chk("R1 status", {16'b0, v}, 32'h0);
        rd(A_IEN, v);  chk("R1 enable", {16'b0, v}, 32'h0);
        rd(A_REXT, v); chk("R1 rx staging", {16'b0, v}, 32'h0);
        rd(A_WEXT, v); chk("R1 tx staging", {16'b0, v}, 32'h0);
        chk("R1 lines", {30'b0, scl_oe, sda_oe}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        // R2 readback
        wr(A_IEN, 16'hE000); rd(A_IEN, v); chk("R2 enable readback", {16'b0, v}, 32'hE000);
        // R3/R4 two-byte write
        drv_write(SL_ADDR, 1'b1, 1'b0, 16'h3412, 2);
        rd(A_WEXT, v); chk("R2 tx staging readback", {16'b0, v}, 32'h3412);
        rd(A_BUSY, v); chk("R2 busy flag", {16'b0, v}, 32'h1);
        wait_ev(s);
        chk("R4 tx event", {16'b0, s}, 32'h4000);
        chk("R10 irq on enabled event", {31'b0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        chk("R4 bus released", {30'b0, scl_oe, sda_oe}, 32'h0);
        // R9 write-one-to-clear
        wr(A_STAT, 16'h0000); rd(A_STAT, v); chk("R9 zero write keeps", {16'b0, v}, 32'h4000);
        wr(A_STAT, 16'h4000); rd(A_STAT, v); chk("R9 one write clears", {16'b0, v}, 32'h0);
        chk("R10 irq low after clear", {31'b0, irq}, 32'h0);
        // R5 two-byte read
        ack_log.delete();
        wr(A_CMD, cmd(SL_ADDR, 1'b0, 1'b1, 1'b0, 1'b0));
        wait_ev(s);
        chk("R5 rx event", {16'b0, s}, 32'h8000);
        rd(A_REXT, v); chk("R5 rx byte order", {16'b0, v}, 32'h3CA5);
        chk("R5 ack count", ack_log.size(), 2);
        if (ack_log.size() == 2) begin
            chk("R5 first byte acked", ack_log[0], 1);
            chk("R5 last byte nacked", ack_log[1], 0);
        end
        // R10 masking
        wr(A_IEN, 16'h4000); @(negedge clk);
        chk("R10 masked event", {31'b0, irq}, 32'h0);
        wr(A_IEN, 16'hE000); wr(A_STAT, 16'hE000);
        // R5 one-byte read
        ack_log.delete();
        wr(A_CMD, cmd(SL_ADDR, 1'b0, 1'b0, 1'b0, 1'b0));
        wait_ev(s);
        chk("R5 one-byte rx event", {16'b0, s}, 32'h8000);
        rd(A_REXT, v); chk("R5 one-byte data", {16'b0, v}, 32'h00A5);
        chk("R5 single byte nacked", (ack_log.size() == 1 && ack_log[0] == 0) ? 1 : 0, 1);
        wr(A_STAT, 16'hE000);
        // R6 probes
        wr(A_CMD, cmd(7'h22, 1'b0, 1'b0, 1'b1, 1'b0));
        wait_ev(s);
        chk("R6 absent target error", {16'b0, s}, 32'h2000);
        repeat (4) @(negedge clk);
        chk("R6 bus released after probe", {30'b0, scl_oe, sda_oe}, 32'h0);
        wr(A_STAT, 16'hE000);
        wr(A_CMD, cmd(SL_ADDR, 1'b0, 1'b0, 1'b1, 1'b0));
        wait_ev(s);
        chk("R6 present target", {16'b0, s}, 32'h8000);
        wr(A_STAT, 16'hE000);
        // R7 data refused
        sl_nack_data = 1'b1;
        drv_write(SL_ADDR, 1'b1, 1'b0, 16'h8877, 1);
        wait_ev(s);
        chk("R7 data nack error only", {16'b0, s}, 32'h2000);
        repeat (4) @(negedge clk);
        chk("R7 stop after nack", {30'b0, scl_oe, sda_oe}, 32'h0);
        sl_nack_data = 1'b0;
        wr(A_STAT, 16'hE000);
        // R8 held write then repeated START read
        drv_write(SL_ADDR, 1'b0, 1'b1, 16'h005A, 1);
        wait_ev(s);
        chk("R8 held write event", {16'b0, s}, 32'h4000);
        repeat (20) @(negedge clk);
        chk("R8 SCL held low", {31'b0, scl_oe}, 32'h1);
        wr(A_STAT, 16'hE000);
        wr(A_CMD, cmd(SL_ADDR, 1'b0, 1'b0, 1'b0, 1'b0));
        wait_ev(s);
        chk("R8 repeated-start read", {16'b0, s}, 32'h8000);
        rd(A_REXT, v); chk("R8 data after repeated start", {16'b0, v}, 32'h00A5);
        repeat (4) @(negedge clk);
        chk("R8 released after final", {30'b0, scl_oe, sda_oe}, 32'h0);
        wr(A_STAT, 16'hE000);
        // R11 command while busy
        drv_write(SL_ADDR, 1'b0, 1'b0, 16'h0066, 1);
        wr(A_CMD, cmd(7'h22, 1'b0, 1'b0, 1'b1, 1'b0));
        wait_ev(s);
        chk("R11 running write unaffected", {16'b0, s}, 32'h4000);
        wr(A_STAT, 16'hE000);
        repeat (300) @(negedge clk);
        rd(A_STAT, v); chk("R11 no later transaction", {16'b0, v}, 32'h0);
        chk("R11 lines idle", {30'b0, scl_oe, sda_oe}, 32'h0);
        // R3 invalid mode bits
        wr(A_CMD, cmd(SL_ADDR, 1'b0, 1'b0, 1'b1, 1'b0) ^ 16'hC000);
        repeat (300) @(negedge clk);
        rd(A_STAT, v); chk("R3 bad mode ignored status", {16'b0, v}, 32'h0);
        rd(A_BUSY, v); chk("R3 bad mode not busy", {16'b0, v}, 32'h0);
        chk("R3 bad mode lines idle", {30'b0, scl_oe, sda_oe}, 32'h0);
        // R12 SCL period
        wr(A_CMD, cmd(SL_ADDR, 1'b0, 1'b0, 1'b1, 1'b0));
        @(posedge scl_w);
        @(posedge scl_w); t1 = cyc;
        @(posedge scl_w); t2 = cyc;
        chk("R12 SCL period", 32'(t2 - t1), 32'(4 * QD));
        wait_ev(s);
        chk("R12 probe after timing", {16'b0, s}, 32'h8000);
        wr(A_STAT, 16'hE000);
        chk("R3 all expected bytes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule